// File: doc/BRIEF.md
# Multi-Channel Boot Image Loader

This block sits behind six byte-wide input channels and waits after reset for one of them to begin sending. The first channel that shows a valid byte wins, and the block stays locked to it until the next reset. No other channel is ever given a ready. Bytes from the chosen channel are packed into 32-bit words, and the word stream is read as a boot image. The image starts with a fixed six-word header, continues with any number of length-prefixed load blocks, and ends with a zero-length block.

Header word 1 carries a code that selects half-speed or full-speed synchronous SRAM. Word 5 carries the program entry address, and the remaining header words must be zero. Each load block gives a length in bytes, then a destination address, then its data words. The block turns every data word into one write on a valid/ready memory port, at consecutive word addresses.

When the terminator arrives, the block raises a one-cycle done strobe and presents the entry address and the speed setting. A malformed header stops the block with a sticky error.

Top module: `boot_stream_loader`

## Requirements
- R1: After reset `done`, `error` and `mem_valid` are 0, and every `ch_ready` bit is 0 while no `ch_valid` bit is set.
- R2: The block locks to the first channel that raises `ch_valid`. If several channels raise it in the same cycle, the lowest channel index wins.
- R3: After the lock, no other channel ever sees `ch_ready` high until reset, even while it holds `ch_valid` high.
- R4: Channel bytes form 32-bit words with the least significant byte first: byte k of a word goes to bits [8k+7:8k].
- R5: A header word 1 of 0x00003779 gives `speed_full`=0 and 0x0000377D gives `speed_full`=1. Header word 5 is reported on `start_addr`.
- R6: A header word 1 that is neither legal code, or a nonzero header word 2, 3, 4 or 6, sets `error`. The error stays set until reset, no further byte is accepted, and `done` never rises.
- R7: A load block is a length word L, a destination word D, and then L/4 data words (the two low bits of L are ignored). Data word k is written to address D+4k with the word as data.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_valid` hold. All `ch_ready` bits stay 0 while a write is pending.
- R9: A length word of 0 ends loading. `done` is high for exactly one cycle, with `start_addr` and `speed_full` valid. After that no byte is accepted and no write is issued until reset.
- R10: An image with no load blocks (header directly followed by the terminator) completes with `done` and no memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_valid | input | 6 | Per-channel byte valid |
| ch_data | input | 48 | Per-channel byte, channel i in bits [8i+7:8i] |
| ch_ready | output | 6 | Per-channel byte ready |
| mem_valid | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data word |
| mem_ready | input | 1 | Memory write accepted |
| done | output | 1 | One-cycle load-complete strobe |
| error | output | 1 | Sticky header error |
| start_addr | output | 32 | Entry address from the header |
| speed_full | output | 1 | 1 = full-speed SRAM code, 0 = half-speed |

## Verification
Some properties hold on every cycle and are checked that way. Once locked, the channel choice is stable and at most one channel sees ready. A stalled memory write holds its address and data, and no channel gets ready while the write is pending. The error flag is sticky, done lasts a single cycle, and a packed word holds while it waits.

Other behaviours only show up at the ports across a whole scenario, and the bench covers them. These are the priority among channels that start together, the byte order within a word, and the write addresses inside each block. The bench also shows the header codes reaching `start_addr` and `speed_full`, the image with no load blocks, and the silence of a losing channel that keeps its valid high throughout.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

    localparam int WORD_W         = 32;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int HDR_WORDS      = 6;
    localparam int HDR_IW         = $clog2(HDR_WORDS);
    localparam int SPEED_SLOT     = 0;
    localparam int ENTRY_SLOT     = 4;

    localparam logic [WORD_W-1:0] SPD_HALF = 32'h0000_3779;
    localparam logic [WORD_W-1:0] SPD_FULL = 32'h0000_377D;

    typedef enum logic [2:0] {
        PS_HDR,
        PS_LEN,
        PS_DST,
        PS_DATA,
        PS_DONE,
        PS_FAIL
    } parse_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } mem_wr_t;

    function automatic logic speed_legal(input logic [WORD_W-1:0] w);
        return (w == SPD_HALF) || (w == SPD_FULL);
    endfunction

endpackage

// File: rtl/boot_chan_arb.sv
module boot_chan_arb
    import boot_ldr_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        ch_valid,
    input  logic [NCH*BYTE_W-1:0] ch_data,
    output logic [NCH-1:0]        ch_ready,
    output logic                  dn_valid,
    output logic [BYTE_W-1:0]     dn_data,
    input  logic                  dn_ready
);

    logic             locked_q;
    logic [IDX_W-1:0] sel_q;
    logic [IDX_W-1:0] pick;
    logic             any_valid;
    logic [IDX_W-1:0] idx;

    always_comb begin
        pick      = '0;
        any_valid = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ch_valid[i]) begin
                pick      = IDX_W'(i);
                any_valid = 1'b1;
            end
        end
    end

    assign idx      = locked_q ? sel_q : pick;
    assign dn_valid = locked_q ? ch_valid[idx] : any_valid;
    assign dn_data  = ch_data[idx*BYTE_W +: BYTE_W];

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_ready[i] = (locked_q || any_valid) && (idx == IDX_W'(i)) && dn_ready;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            sel_q    <= '0;
        end else if (!locked_q && any_valid) begin
            locked_q <= 1'b1;
            sel_q    <= pick;
        end
    end

    // R2
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> (locked_q && $stable(sel_q)));

    // R3
    single_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_ready));

endmodule

// File: rtl/boot_word_pack.sv
module boot_word_pack
    import boot_ldr_pkg::*;
#(
    parameter int NBYTES = BYTES_PER_WORD,
    parameter int CNT_W  = $clog2(NBYTES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [BYTE_W-1:0]        in_data,
    output logic                     in_ready,
    output logic                     out_valid,
    output logic [NBYTES*BYTE_W-1:0] out_word,
    input  logic                     out_ready
);

    logic [CNT_W-1:0]         cnt_q;
    logic [NBYTES*BYTE_W-1:0] shreg_q;
    logic                     full_q;

    assign in_ready  = !full_q;
    assign out_valid = full_q;
    assign out_word  = shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            full_q  <= 1'b0;
        end else begin
            if (full_q && out_ready) begin
                full_q <= 1'b0;
            end
            if (in_valid && !full_q) begin
                shreg_q[cnt_q*BYTE_W +: BYTE_W] <= in_data;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(NBYTES - 1)) begin
                    full_q <= 1'b1;
                end
            end
        end
    end

    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full_q && !out_ready) |=> (full_q && $stable(out_word)));

endmodule

// File: rtl/boot_stream_parser.sv
module boot_stream_parser
    import boot_ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              w_valid,
    input  logic [WORD_W-1:0] w_word,
    output logic              w_ready,
    output logic              mem_valid,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_data,
    input  logic              mem_ready,
    output logic              done,
    output logic              error,
    output logic [WORD_W-1:0] start_addr,
    output logic              speed_full
);

    parse_st_e         st_q;
    logic [HDR_IW-1:0] hdr_idx_q;
    logic [WORD_W-3:0] remain_q;
    logic [WORD_W-1:0] cur_addr_q;
    mem_wr_t           wr_q;
    logic              wr_vld_q;
    logic              done_q;
    logic              take;
    logic              hdr_bad;

    assign w_ready    = (st_q inside {PS_HDR, PS_LEN, PS_DST, PS_DATA}) && !wr_vld_q;
    assign take       = w_valid && w_ready;
    assign mem_valid  = wr_vld_q;
    assign mem_addr   = wr_q.addr;
    assign mem_data   = wr_q.data;
    assign done       = done_q;
    assign error      = (st_q == PS_FAIL);

    always_comb begin
        if (hdr_idx_q == HDR_IW'(SPEED_SLOT)) begin
            hdr_bad = !speed_legal(w_word);
        end else if (hdr_idx_q == HDR_IW'(ENTRY_SLOT)) begin
            hdr_bad = 1'b0;
        end else begin
            hdr_bad = (w_word != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= PS_HDR;
            hdr_idx_q  <= '0;
            remain_q   <= '0;
            cur_addr_q <= '0;
            wr_q       <= '0;
            wr_vld_q   <= 1'b0;
            done_q     <= 1'b0;
            start_addr <= '0;
            speed_full <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (wr_vld_q && mem_ready) begin
                wr_vld_q <= 1'b0;
            end
            if (take) begin
                unique case (st_q)
                    PS_HDR: begin
                        if (hdr_bad) begin
                            st_q <= PS_FAIL;
                        end else begin
                            if (hdr_idx_q == HDR_IW'(SPEED_SLOT)) begin
                                speed_full <= (w_word == SPD_FULL);
                            end
                            if (hdr_idx_q == HDR_IW'(ENTRY_SLOT)) begin
                                start_addr <= w_word;
                            end
                            if (hdr_idx_q == HDR_IW'(HDR_WORDS - 1)) begin
                                st_q <= PS_LEN;
                            end
                            hdr_idx_q <= hdr_idx_q + 1'b1;
                        end
                    end
                    PS_LEN: begin
                        if (w_word == '0) begin
                            done_q <= 1'b1;
                            st_q   <= PS_DONE;
                        end else begin
                            remain_q <= w_word[WORD_W-1:2];
                            st_q     <= PS_DST;
                        end
                    end
                    PS_DST: begin
                        cur_addr_q <= w_word;
                        st_q       <= (remain_q == '0) ? PS_LEN : PS_DATA;
                    end
                    PS_DATA: begin
                        wr_vld_q   <= 1'b1;
                        wr_q.addr  <= cur_addr_q;
                        wr_q.data  <= w_word;
                        cur_addr_q <= cur_addr_q + WORD_W'(BYTES_PER_WORD);
                        remain_q   <= remain_q - 1'b1;
                        if (remain_q == (WORD_W-2)'(1)) begin
                            st_q <= PS_LEN;
                        end
                    end
                    default: st_q <= st_q;
                endcase
            end
        end
    end

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        error |=> (error && !done));

endmodule

// File: rtl/boot_stream_loader.sv
module boot_stream_loader
    import boot_ldr_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        ch_valid,
    input  logic [NCH*BYTE_W-1:0] ch_data,
    output logic [NCH-1:0]        ch_ready,
    output logic                  mem_valid,
    output logic [WORD_W-1:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_data,
    input  logic                  mem_ready,
    output logic                  done,
    output logic                  error,
    output logic [WORD_W-1:0]     start_addr,
    output logic                  speed_full
);

    logic              sel_valid;
    logic [BYTE_W-1:0] sel_data;
    logic              sel_ready;
    logic              pk_in_ready;
    logic              wd_valid;
    logic [WORD_W-1:0] wd_word;
    logic              wd_ready;

    // the stream advances only while the parser is open for a new word
    assign sel_ready = pk_in_ready && wd_ready;

    boot_chan_arb #(.NCH(NCH)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .ch_valid (ch_valid),
        .ch_data  (ch_data),
        .ch_ready (ch_ready),
        .dn_valid (sel_valid),
        .dn_data  (sel_data),
        .dn_ready (sel_ready)
    );

    boot_word_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sel_valid && wd_ready),
        .in_data   (sel_data),
        .in_ready  (pk_in_ready),
        .out_valid (wd_valid),
        .out_word  (wd_word),
        .out_ready (wd_ready)
    );

    boot_stream_parser u_parse (
        .clk        (clk),
        .rst        (rst),
        .w_valid    (wd_valid),
        .w_word     (wd_word),
        .w_ready    (wd_ready),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_ready  (mem_ready),
        .done       (done),
        .error      (error),
        .start_addr (start_addr),
        .speed_full (speed_full)
    );

    // R8
    stall_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |-> (ch_ready == '0));

    // R9
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ((ch_ready == '0) && !mem_valid));

endmodule

// File: tb/boot_stream_loader_tb.sv
module boot_stream_loader_tb;

    localparam int NCH = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  ch_valid = '0;
    logic [NCH*8-1:0] ch_data = '0;
    logic [NCH-1:0]  ch_ready;
    logic            mem_valid;
    logic [31:0]     mem_addr;
    logic [31:0]     mem_data;
    logic            mem_ready = 1'b1;
    logic            done;
    logic            error;
    logic [31:0]     start_addr;
    logic            speed_full;

    int tests = 0;
    int fails = 0;

    logic [63:0] exp_q[$];
    int          exp_ch = -1;
    int          foreign_rdy = 0;
    int          any_rdy = 0;
    int          done_cnt = 0;
    logic [31:0] done_start = '0;
    logic        done_speed = 1'b0;
    int          stall_mode = 0;
    int          stall_ctr = 0;
    logic        hold_pending = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [31:0] hold_data = '0;

    always #10 clk = ~clk;

    boot_stream_loader #(.NCH(NCH)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ch_valid   (ch_valid),
        .ch_data    (ch_data),
        .ch_ready   (ch_ready),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_ready  (mem_ready),
        .done       (done),
        .error      (error),
        .start_addr (start_addr),
        .speed_full (speed_full)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory ready pattern, changed away from the edge
    always @(posedge clk) begin
        #2;
        stall_ctr++;
        if (stall_mode == 0) mem_ready = 1'b1;
        else                 mem_ready = (stall_ctr % 3 == 0);
    end

    // monitor: scoreboard pop and per-cycle observations
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pending) begin
                chk(mem_valid && mem_addr == hold_addr && mem_data == hold_data,
                    "R8 hold", {mem_addr, mem_data}, {hold_addr, hold_data});
            end
            hold_pending = mem_valid && !mem_ready;
            hold_addr    = mem_addr;
            hold_data    = mem_data;
            if (mem_valid && mem_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected write", {mem_addr, mem_data}, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk({mem_addr, mem_data} == e, "R7 write", {mem_addr, mem_data}, e);
                end
            end
            if (done) begin
                done_cnt++;
                done_start = start_addr;
                done_speed = speed_full;
            end
            for (int i = 0; i < NCH; i++) begin
                if (ch_ready[i]) begin
                    any_rdy++;
                    if (i != exp_ch) foreign_rdy++;
                end
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        ch_valid = '0;
        ch_data = '0;
        repeat (3) @(posedge clk);
        #2;
        exp_q.delete();
        foreign_rdy = 0;
        any_rdy = 0;
        done_cnt = 0;
        hold_pending = 1'b0;
        rst = 1'b0;
        @(posedge clk);
        #2;
    endtask

    task automatic send_byte(input int ch, input logic [7:0] b);
        bit got;
        ch_valid[ch] = 1'b1;
        ch_data[ch*8 +: 8] = b;
        got = 1'b0;
        while (!got) begin
            @(negedge clk);
            got = ch_ready[ch];
            @(posedge clk);
            #2;
        end
    endtask

    task automatic send_word(input int ch, input logic [31:0] w);
        for (int k = 0; k < 4; k++) send_byte(ch, w[8*k +: 8]);
    endtask

    task automatic send_hdr(input int ch, input logic [31:0] spd, input logic [31:0] entry);
        send_word(ch, spd);
        send_word(ch, 32'h0);
        send_word(ch, 32'h0);
        send_word(ch, 32'h0);
        send_word(ch, entry);
        send_word(ch, 32'h0);
    endtask

    task automatic send_block(input int ch, input logic [31:0] dest, input int n, input logic [31:0] seed);
        send_word(ch, 32'(n * 4));
        send_word(ch, dest);
        for (int k = 0; k < n; k++) begin
            logic [31:0] d;
            d = seed ^ (32'h0101_0101 * 32'(k + 1));
            exp_q.push_back({dest + 32'(4 * k), d});
            send_word(ch, d);
        end
    endtask

    task automatic finish_stream(input int ch);
        ch_valid[ch] = 1'b0;
        repeat (20) @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        chk(!done && !error && !mem_valid && ch_ready == '0, "R1 reset",
            {60'h0, done, error, mem_valid, |ch_ready}, 64'h0);
        @(posedge clk); #2;

        // channel 3 alone, full speed, two blocks, stalled memory; channel 5 raises valid after lock
        exp_ch = 3;
        stall_mode = 1;
        send_word(3, 32'h0000_377D);
        ch_valid[5] = 1'b1;
        ch_data[5*8 +: 8] = 8'h5A;
        send_word(3, 32'h0); send_word(3, 32'h0); send_word(3, 32'h0);
        send_word(3, 32'h0000_1000);
        send_word(3, 32'h0);
        send_block(3, 32'h0000_0200, 3, 32'hA1B2_C3D4);
        send_block(3, 32'h0000_0800, 1, 32'h1234_5678);
        send_word(3, 32'h0);
        finish_stream(3);
        chk(done_cnt == 1, "R9 done once", 64'(done_cnt), 64'd1);
        chk(done_start == 32'h0000_1000, "R5 entry address", {32'h0, done_start}, 64'h1000);
        chk(done_speed == 1'b1, "R5 full speed code", {63'h0, done_speed}, 64'd1);
        chk(exp_q.size() == 0, "R7 all writes seen", 64'(exp_q.size()), 64'd0);
        chk(foreign_rdy == 0, "R3 channel 5 ignored", 64'(foreign_rdy), 64'd0);
        chk(!error, "R6 no error on good image", {63'h0, error}, 64'd0);
        // R9: after done, held valid gets no ready and no writes
        any_rdy = 0;
        ch_valid[3] = 1'b1;
        repeat (10) @(posedge clk);
        #2;
        chk(any_rdy == 0 && !mem_valid, "R9 idle after done", 64'(any_rdy), 64'd0);

        // R2: channels 2 and 4 start together, half speed; R4 byte order
        do_reset();
        exp_ch = 2;
        stall_mode = 0;
        ch_valid[4] = 1'b1;
        ch_data[4*8 +: 8] = 8'hEE;
        send_hdr(2, 32'h0000_3779, 32'h8000_0040);
        send_block(2, 32'h0010_0000, 2, 32'h0403_0201);
        send_word(2, 32'h0);
        finish_stream(2);
        chk(exp_q.size() == 0, "R4 R7 packed words written", 64'(exp_q.size()), 64'd0);
        chk(foreign_rdy == 0, "R2 lowest index wins, R3 channel 4 ignored", 64'(foreign_rdy), 64'd0);
        chk(done_cnt == 1 && done_speed == 1'b0, "R5 half speed code", {63'h0, done_speed}, 64'd0);
        chk(done_start == 32'h8000_0040, "R5 entry address 2", {32'h0, done_start}, 64'h8000_0040);

        // R10: header then terminator, on channel 0
        do_reset();
        exp_ch = 0;
        send_hdr(0, 32'h0000_377D, 32'h0000_0400);
        send_word(0, 32'h0);
        finish_stream(0);
        chk(done_cnt == 1 && done_start == 32'h0000_0400, "R10 empty image done",
            {32'(done_cnt), done_start}, {32'd1, 32'h400});
        chk(foreign_rdy == 0 && exp_q.size() == 0, "R10 no writes", 64'(exp_q.size()), 64'd0);

        // R6: illegal speed code on channel 1
        do_reset();
        exp_ch = 1;
        send_word(1, 32'h1234_5678);
        repeat (5) @(posedge clk); #2;
        chk(error == 1'b1, "R6 bad speed code", {63'h0, error}, 64'd1);
        any_rdy = 0;
        ch_valid[1] = 1'b1;
        repeat (10) @(posedge clk); #2;
        chk(any_rdy == 0 && error && done_cnt == 0, "R6 halted and sticky", 64'(any_rdy), 64'd0);

        // R6: nonzero sixth header word on channel 5
        do_reset();
        exp_ch = 5;
        send_word(5, 32'h0000_3779);
        send_word(5, 32'h0); send_word(5, 32'h0); send_word(5, 32'h0);
        send_word(5, 32'h0000_2000);
        chk(error == 1'b0, "R6 no error before bad word", {63'h0, error}, 64'd0);
        send_word(5, 32'h0000_0001);
        repeat (5) @(posedge clk); #2;
        chk(error == 1'b1 && done_cnt == 0, "R6 bad header word 6", {63'h0, error}, 64'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule